// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins two 18-bit ports, A and B, with one storage lane per direction. Each lane has its own mode control. With its latch control high, a lane passes data straight through. With the latch control low, it holds its last value. While the latch control is low, a rising edge on the lane's device clock loads new data, but only when the lane's active-low clock gate is open. An active-low output enable decides whether the lane drives the far port. The pins that would be shared are split into an input vector, an output vector and a drive-enable vector for each port, so the tri-state decision stays with the pad ring.

The whole block runs on one system clock. The device clock and the latch control are treated as sampled levels. A device-clock rising edge is seen when the sample at one system edge is high and the sample at the previous system edge was low. A flag goes high when both directions drive at the same time, which would make the shared bus fight.

Top module: `bidi_reg_xcvr`

## Requirements
- R1: The two directions are independent. Controls of the A-to-B lane never change the B-to-A lane's output or drive, and the reverse also holds. One control set governs all 18 bits of its lane.
- R2: While a lane's latch control is high, its output equals its input in the same cycle. The storage also loads that input at every system clock edge, so the last input seen before the latch control falls is retained.
- R3: While the latch control is low and the clock gate is low, a device-clock rising edge loads the input into storage. A rising edge means a sample of 1 after a sample of 0 at the previous system edge. The new value appears on the output after that system edge.
- R4: While the latch control is low and the device clock stays at one level (either 0 or 1), the output holds its stored value whatever the input does.
- R5: While the clock gate is high, device-clock rising edges load nothing and the stored value is kept.
- R6: If the latch control falls while the device clock is high, the value from before the fall is kept. Nothing is loaded until a later rising edge that meets the R3 conditions.
- R7: With the output enable low, every bit of the lane's drive-enable vector is 1. With it high, every bit is 0. The output vector carries the lane value in both cases.
- R8: The reset is active low and asserted asynchronously. While it is asserted, both storages read zero and both drive-enable vectors are zero. Release is synchronised over two system clocks. Out of reset, the previous device-clock sample counts as 1, so a device clock already high at release is not an edge.
- R9: The contention flag is 1 exactly when both drive-enable vectors are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| a_in | input | 18 | Data sampled from the A port |
| b_in | input | 18 | Data sampled from the B port |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch control, high = pass-through |
| ab_dclk | input | 1 | A-to-B device clock (sampled) |
| ab_dce_n | input | 1 | A-to-B clock gate, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch control, high = pass-through |
| ba_dclk | input | 1 | B-to-A device clock (sampled) |
| ba_dce_n | input | 1 | B-to-A clock gate, active low |
| b_out | output | 18 | Value presented to the B port |
| b_drv | output | 18 | Drive enable for the B port, per bit |
| a_out | output | 18 | Value presented to the A port |
| a_drv | output | 18 | Drive enable for the A port, per bit |
| bus_fight | output | 1 | Both directions driving at once |

## Verification
One mode sequence is applied to each lane in turn while the other lane sits idle. The idle lane's output must stay flat throughout, which exposes any coupling between the lanes. The data patterns are alternating-bit, all-ones, all-zeros, a single bit and mixed words, so a dropped or swapped bit shows up. Held steps feed new input that must not reach the output, which separates capture from pass-through. Three more steps tell the edge rules apart: a rising edge with the clock gate closed, a device clock held high, and the latch control falling with the clock high. Directed steps cover a clock that is high at reset release, an asynchronous reset in mid-run, and the contention flag with one lane driving and with both lanes driving.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DATA_W = 18;
  localparam int unsigned NUM_DIR = 2;

  typedef struct packed {
    logic le;
    logic dclk;
    logic dce_n;
    logic oe_n;
  } lane_ctrl_t;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic       clk,
  input  logic       rst_ok,
  input  logic [W-1:0] din,
  input  lane_ctrl_t ctl,
  output logic [W-1:0] dout,
  output logic [W-1:0] drv
);
  logic [W-1:0] store_q, store_d;
  logic         dclk_q;
  logic         live_q;
  logic         rise;
  logic         load_en;

  always_comb begin
    rise    = ctl.dclk & ~dclk_q;
    load_en = ctl.le | (rise & ~ctl.dce_n);
    store_d = store_q;
    if (load_en) store_d = din;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      store_q <= '0;
      dclk_q  <= 1'b1;
      live_q  <= 1'b0;
    end else begin
      store_q <= store_d;
      dclk_q  <= ctl.dclk;
      live_q  <= 1'b1;
    end
  end

  assign dout = ctl.le ? din : store_q;
  assign drv  = {W{~ctl.oe_n & live_q}};

  assert_pass_load_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    ctl.le |=> (store_q == $past(din)));

  assert_edge_load_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ctl.le && !ctl.dce_n && ctl.dclk && !dclk_q) |=> (dout == $past(din)));

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ctl.le && ctl.dce_n) |=> $stable(store_q));

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ctl.le && ctl.dclk == dclk_q) |=> $stable(store_q));

  assert_drive_off_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    ctl.oe_n |-> (drv == '0));
endmodule

// File: rtl/bidi_reg_xcvr.sv
module bidi_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_dclk,
  input  logic         ab_dce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_dclk,
  input  logic         ba_dce_n,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv,
  output logic         bus_fight
);
  logic         rst_ok;
  logic [W-1:0] din_v  [NUM_DIR];
  logic [W-1:0] dout_v [NUM_DIR];
  logic [W-1:0] drv_v  [NUM_DIR];
  lane_ctrl_t   ctl_v  [NUM_DIR];

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  assign din_v[0] = a_in;
  assign din_v[1] = b_in;
  assign ctl_v[0] = '{le: ab_le, dclk: ab_dclk, dce_n: ab_dce_n, oe_n: ab_oe_n};
  assign ctl_v[1] = '{le: ba_le, dclk: ba_dclk, dce_n: ba_dce_n, oe_n: ba_oe_n};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk    (clk),
      .rst_ok (rst_ok),
      .din    (din_v[d]),
      .ctl    (ctl_v[d]),
      .dout   (dout_v[d]),
      .drv    (drv_v[d])
    );
  end

  assign b_out     = dout_v[0];
  assign b_drv     = drv_v[0];
  assign a_out     = dout_v[1];
  assign a_drv     = drv_v[1];
  assign bus_fight = (|drv_v[0]) & (|drv_v[1]);

  assert_fight_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    bus_fight |-> (!ab_oe_n && !ba_oe_n));

  assert_lane_split_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ba_le && ba_dce_n) |=> $stable(a_out));
endmodule

// File: tb/sim_bidi_reg_xcvr.sv
`timescale 1ns/1ps
module sim_bidi_reg_xcvr;
  localparam int W = 18;
  localparam int NROW = 16;
  // row: {le, dclk, dce_n, oe_n, din[17:0], expect[17:0], expect_drv}
  localparam logic [40:0] TBL [NROW] = '{
    {4'b1000, 18'h15555, 18'h15555, 1'b1},
    {4'b1000, 18'h2AAAA, 18'h2AAAA, 1'b1},
    {4'b0000, 18'h00001, 18'h2AAAA, 1'b1},
    {4'b0000, 18'h3FFFF, 18'h2AAAA, 1'b1},
    {4'b0100, 18'h12345, 18'h12345, 1'b1},
    {4'b0100, 18'h00F0F, 18'h12345, 1'b1},
    {4'b0000, 18'h0F0F0, 18'h12345, 1'b1},
    {4'b0110, 18'h0F0F0, 18'h12345, 1'b1},
    {4'b0010, 18'h0F0F0, 18'h12345, 1'b1},
    {4'b0100, 18'h0F0F0, 18'h0F0F0, 1'b1},
    {4'b0101, 18'h00AAA, 18'h0F0F0, 1'b0},
    {4'b1100, 18'h3FFFF, 18'h3FFFF, 1'b1},
    {4'b0100, 18'h00000, 18'h3FFFF, 1'b1},
    {4'b0100, 18'h11111, 18'h3FFFF, 1'b1},
    {4'b0000, 18'h11111, 18'h3FFFF, 1'b1},
    {4'b0100, 18'h22222, 18'h22222, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out, a_drv, b_drv;
  logic ab_oe_n, ab_le, ab_dclk, ab_dce_n;
  logic ba_oe_n, ba_le, ba_dclk, ba_dce_n;
  logic bus_fight;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bidi_reg_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_dclk(ab_dclk), .ab_dce_n(ab_dce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_dclk(ba_dclk), .ba_dce_n(ba_dce_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
    .bus_fight(bus_fight)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 2, 3, 11: return "R2";
      4, 9, 15:       return "R3";
      5, 6:           return "R4";
      7, 8:           return "R5";
      10:             return "R7";
      default:        return "R6";
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_in = 18'h3C3C3; b_in = 18'h0A5A5;
    ab_le = 1'b0; ab_dclk = 1'b1; ab_dce_n = 1'b0; ab_oe_n = 1'b0;
    ba_le = 1'b0; ba_dclk = 1'b0; ba_dce_n = 1'b1; ba_oe_n = 1'b0;
    tick(); tick();
    // R8: reset state, drives off even with both enables low
    chk("R8 reset b_out", b_out, '0);
    chk("R8 reset a_out", a_out, '0);
    chk("R8 reset b_drv", b_drv, '0);
    chk("R8 reset a_drv", a_drv, '0);
    chk("R9 no fight in reset", {17'd0, bus_fight}, 18'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) tick();
    // R8: device clock high at release is not an edge
    chk("R8 no capture at release", b_out, '0);
    chk("R9 fight both driving", {17'd0, bus_fight}, 18'd1);
    chk("R7 b_drv all ones", b_drv, '1);
    ba_oe_n = 1'b1;
    tick();
    chk("R9 no fight one driving", {17'd0, bus_fight}, 18'd0);
    ab_dclk = 1'b0; tick();
    ab_dclk = 1'b1; tick();
    chk("R3 first edge after reset", b_out, 18'h3C3C3);

    // A-to-B table; B-to-A idle and must stay flat (R1)
    ab_dclk = 1'b0; tick();
    for (int i = 0; i < NROW; i++) begin
      {ab_le, ab_dclk, ab_dce_n, ab_oe_n} = TBL[i][40:37];
      a_in = TBL[i][36:19];
      b_in = ~TBL[i][36:19];
      tick();
      chk({row_tag(i), " a->b out"}, b_out, TBL[i][18:1]);
      chk({row_tag(i), " a->b drv"}, b_drv, {W{TBL[i][0]}});
      chk("R1 idle b->a out", a_out, '0);
      chk("R1 idle b->a drv", a_drv, '0);
    end

    // B-to-A table; A-to-B idle
    ab_le = 1'b0; ab_dclk = 1'b0; ab_dce_n = 1'b1; ab_oe_n = 1'b1;
    ba_le = 1'b0; ba_dclk = 1'b0; ba_dce_n = 1'b0; ba_oe_n = 1'b0;
    tick();
    for (int i = 0; i < NROW; i++) begin
      {ba_le, ba_dclk, ba_dce_n, ba_oe_n} = TBL[i][40:37];
      b_in = TBL[i][36:19];
      a_in = ~TBL[i][36:19];
      tick();
      chk({row_tag(i), " b->a out"}, a_out, TBL[i][18:1]);
      chk({row_tag(i), " b->a drv"}, a_drv, {W{TBL[i][0]}});
      chk("R1 idle a->b out", b_out, 18'h22222);
      chk("R1 idle a->b drv", b_drv, '0);
    end

    // R8: asynchronous clear mid-run, checked before any clock edge
    ba_le = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 async clear a_out", a_out, '0);
    chk("R8 async clear b_out", b_out, '0);
    chk("R8 async clear a_drv", a_drv, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule